// File: doc/BRIEF.md
# Per-Core Interrupt CPU Interface

This block sits between an interrupt distributor and one processor core. The distributor offers its single best pending candidate: a valid flag, an ID, an 8-bit priority and, for software-generated interrupts, the number of the requesting core. The interface compares that candidate against a software-set priority mask and against the priority of whatever the core is already servicing. It raises the core's interrupt request line only when the candidate is more urgent than both. A numerically lower priority value is more urgent. Only the upper nibble of every priority takes part in the comparison.

Software talks to the block over a simple 32-bit register bus. Reading the acknowledge register claims the candidate: the read returns the ID, marks the interrupt active, raises the running priority to it, and pulses a strobe so the distributor can update its pending state. If nothing qualifies, the read returns the reserved ID 1023 and changes nothing. Writing the claimed ID to the end-of-interrupt register completes it and pulses a second strobe toward the distributor. One level of preemption is kept: a second, more urgent interrupt may be claimed while one is active, and completing it restores the first one's priority.

Registers (byte offsets): 0x00 control, 0x04 priority mask, 0x0C acknowledge, 0x10 end-of-interrupt, 0x14 running priority, 0x18 highest pending ID. Any other offset reads as zero, and writes there are dropped.

Top module: `core_irq_port`

## Requirements
- R1: After reset, `irq_o` is low. Control reads 0, the mask reads 0, running priority reads 0xFF and an acknowledge read returns 1023.
- R2: Bit 0 of the control register (0x00) enables signalling. While it is 0, `irq_o` stays low and acknowledge reads return 1023. Control reads back bit 0 only.
- R3: The mask register (0x04) stores write bits [7:4] only. Bits [3:0] read as zero.
- R4: `irq_o` is high exactly when `cand_valid` is set, signalling is enabled, fewer than two interrupts are active, the candidate's priority bits [7:4] are strictly below the mask nibble, and {those bits, 4'h0} is strictly below the running priority. Candidate priority bits [3:0] have no effect.
- R5: A read at 0x0C while `irq_o` is high returns the candidate ID in bits [9:0]. It returns `cand_src` in bits [12:10] when the ID is below 16, and 0 there otherwise. In that same cycle it pulses `ack_stb` with `ack_id` equal to the ID, and it marks the ID active.
- R6: A read at 0x0C while `irq_o` is low returns 1023, does not pulse `ack_stb`, and changes no state.
- R7: After an acknowledge, the running priority (0x14) reads {candidate priority bits [7:4], 4'h0}. With nothing active it reads 0xFF.
- R8: A second, more urgent interrupt may be acknowledged while one is active. With two active, `irq_o` stays low and acknowledge reads return 1023.
- R9: A write to 0x10 whose bits [9:0] equal the most recently acknowledged, still-active ID pulses `eoi_stb` with `eoi_id`. The running priority then returns to the remaining active interrupt's priority, or to 0xFF.
- R10: A write to 0x10 with any other ID, or with nothing active, is ignored: no strobe, and the running priority is unchanged.
- R11: A read at 0x18 returns `cand_id` when `cand_valid` is set and 1023 otherwise, with no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational from the address |
| cand_valid | input | 1 | Distributor has a pending candidate |
| cand_id | input | ID_W | Candidate interrupt ID |
| cand_prio | input | PRIO_W | Candidate priority, lower is more urgent |
| cand_src | input | SRC_W | Requesting core for software-generated IDs |
| irq_o | output | 1 | Interrupt request to the core |
| ack_stb | output | 1 | Candidate acknowledged this cycle |
| ack_id | output | ID_W | ID acknowledged |
| eoi_stb | output | 1 | Interrupt completed this cycle |
| eoi_id | output | ID_W | ID completed |

## Verification
Candidates are swept across the mask boundary: equal nibbles, lower nibbles, and differing low bits with equal nibbles. This separates a strict from a non-strict comparison and shows that only the upper nibble counts. Acknowledge reads are tried for software-generated IDs and for higher IDs, which shows whether the source field is packed only where it belongs. Nested sequences claim two interrupts, then complete them in the wrong order, in the right order and with nothing active; these cases tell a priority restore apart from a plain reset to idle. A long pseudo-random run of mixed register accesses and changing candidates is compared cycle by cycle against a behavioural model.

// File: rtl/core_irq_port.sv
module core_irq_port #(
  parameter int ID_W      = 10,
  parameter int SRC_W     = 3,
  parameter int PRIO_W    = 8,
  parameter int NIB       = 4,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int SGI_COUNT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              cand_valid,
  input  logic [ID_W-1:0]   cand_id,
  input  logic [PRIO_W-1:0] cand_prio,
  input  logic [SRC_W-1:0]  cand_src,
  output logic              irq_o,
  output logic              ack_stb,
  output logic [ID_W-1:0]   ack_id,
  output logic              eoi_stb,
  output logic [ID_W-1:0]   eoi_id
);
  localparam int LOW_W = PRIO_W - NIB;
  localparam logic [ID_W-1:0]   SPUR    = {ID_W{1'b1}};
  localparam logic [ID_W-1:0]   SGI_LIM = SGI_COUNT[ID_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_EOI   = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_RUN   = ADDR_W'(8'h14);
  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(8'h18);

  logic            en_q;
  logic [NIB-1:0]  mask_q;
  logic [1:0]      depth_q;
  logic [ID_W-1:0] id0_q, id1_q;
  logic [NIB-1:0]  pr0_q, pr1_q;

  logic [NIB-1:0]    cand_n;
  logic [PRIO_W-1:0] run_prio;
  logic [ID_W-1:0]   top_id;
  logic              qual, rd_ack, wr_eoi;
  logic [SRC_W-1:0]  src_field;
  logic              unused_bits;

  assign cand_n   = cand_prio[PRIO_W-1 -: NIB];
  assign run_prio = (depth_q == 2'd0) ? {PRIO_W{1'b1}} :
                    (depth_q == 2'd1) ? {pr0_q, {LOW_W{1'b0}}} : {pr1_q, {LOW_W{1'b0}}};
  assign top_id   = (depth_q == 2'd2) ? id1_q : id0_q;

  assign qual = cand_valid && en_q && (depth_q != 2'd2) &&
                (cand_n < mask_q) && ({cand_n, {LOW_W{1'b0}}} < run_prio);
  assign irq_o = qual;

  assign rd_ack = bus_req && !bus_wr && (bus_addr == A_ACK);
  assign wr_eoi = bus_req &&  bus_wr && (bus_addr == A_EOI);

  assign ack_stb   = rd_ack && qual;
  assign ack_id    = cand_id;
  assign eoi_id    = bus_wdata[ID_W-1:0];
  assign eoi_stb   = wr_eoi && (depth_q != 2'd0) && (eoi_id == top_id);
  assign src_field = (cand_id < SGI_LIM) ? cand_src : '0;

  assign unused_bits = ^{bus_wdata[DATA_W-1:ID_W], cand_prio[LOW_W-1:0]};

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = en_q;
      A_MASK: bus_rdata[PRIO_W-1:0] = {mask_q, {LOW_W{1'b0}}};
      A_ACK:  bus_rdata[ID_W+SRC_W-1:0] = qual ? {src_field, cand_id} : {{SRC_W{1'b0}}, SPUR};
      A_RUN:  bus_rdata[PRIO_W-1:0] = run_prio;
      A_PEND: bus_rdata[ID_W-1:0] = cand_valid ? cand_id : SPUR;
      default: bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mask_q  <= '0;
      depth_q <= 2'd0;
      id0_q   <= '0;
      id1_q   <= '0;
      pr0_q   <= '0;
      pr1_q   <= '0;
    end else begin
      if (bus_req && bus_wr && bus_addr == A_CTRL) en_q   <= bus_wdata[0];
      if (bus_req && bus_wr && bus_addr == A_MASK) mask_q <= bus_wdata[PRIO_W-1 -: NIB];
      if (ack_stb) begin
        if (depth_q == 2'd0) begin
          id0_q <= cand_id;
          pr0_q <= cand_n;
        end else begin
          id1_q <= cand_id;
          pr1_q <= cand_n;
        end
        depth_q <= depth_q + 2'd1;
      end else if (eoi_stb) begin
        depth_q <= depth_q - 2'd1;
      end
    end
  end
endmodule

module core_irq_port_chk #(
  parameter int PRIO_W = 8,
  parameter int NIB    = 4,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PRIO_W-1:0] cand_prio,
  input logic              irq_o,
  input logic              ack_stb,
  input logic              eoi_stb,
  input logic              en_q,
  input logic [NIB-1:0]    mask_q,
  input logic [1:0]        depth_q,
  input logic [PRIO_W-1:0] run_prio
);
  localparam logic [ADDR_W-1:0] A_ACK = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_EOI = ADDR_W'(8'h10);

  a_r2_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en_q);

  a_r4_irq_under_mask: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (cand_prio[PRIO_W-1 -: NIB] < mask_q));

  a_r6_spurious_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && bus_addr == A_ACK && !ack_stb) |=> ($stable(depth_q) && $stable(run_prio)));

  a_r7_ack_sets_running: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> (run_prio == {$past(cand_prio[PRIO_W-1 -: NIB]), {(PRIO_W-NIB){1'b0}}}));

  a_r8_full_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == 2'd2) |-> !irq_o);

  a_r8_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= 2'd2);

  a_r9_eoi_pops: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_stb |=> (depth_q == 2'($past(depth_q) - 2'd1)));

  a_r10_bad_eoi_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr && bus_addr == A_EOI && !eoi_stb) |=> $stable(run_prio));
endmodule

bind core_irq_port core_irq_port_chk #(.PRIO_W(PRIO_W), .NIB(NIB), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .cand_prio(cand_prio), .irq_o(irq_o), .ack_stb(ack_stb), .eoi_stb(eoi_stb),
  .en_q(en_q), .mask_q(mask_q), .depth_q(depth_q), .run_prio(run_prio)
);

// File: tb/core_irq_port_bench.sv
module core_irq_port_bench;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_req = 0, bus_wr = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        cand_valid = 0;
  logic [9:0]  cand_id = 0;
  logic [7:0]  cand_prio = 8'hFF;
  logic [2:0]  cand_src = 0;
  logic        irq_o, ack_stb, eoi_stb;
  logic [9:0]  ack_id, eoi_id;

  core_irq_port u_core_irq_port (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cand_valid(cand_valid), .cand_id(cand_id),
    .cand_prio(cand_prio), .cand_src(cand_src), .irq_o(irq_o), .ack_stb(ack_stb),
    .ack_id(ack_id), .eoi_stb(eoi_stb), .eoi_id(eoi_id)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_vec = 0, n_bad = 0, cycles = 0;
  int m_en = 0, m_mask = 0;
  int act_id[$];
  int act_p[$];

  function automatic int m_rp();
    return (act_p.size() == 0) ? 255 : act_p[act_p.size()-1] * 16;
  endfunction

  function automatic bit m_qual();
    int n = int'(cand_prio) >> 4;
    return cand_valid && m_en != 0 && n < m_mask && n * 16 < m_rp() && act_id.size() < 2;
  endfunction

  task automatic check(string tag, string ctx, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, ctx, act, exp);
    end
  endtask

  task automatic cyc(bit req, bit wr, logic [7:0] a, logic [31:0] wd, string ctx);
    int exp_rd;
    bit q, ea, ee, match;
    string rtag;
    bus_req = req; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    #2;
    q = m_qual();
    match = act_id.size() > 0 && (int'(wd[9:0]) == act_id[act_id.size()-1]);
    ea = req && !wr && a == 8'h0C && q;
    ee = req && wr && a == 8'h10 && match;
    check("R4", ctx, irq_o, q);
    check("R5", ctx, ack_stb, ea);
    if (ea) check("R5", ctx, ack_id, cand_id);
    check(match ? "R9" : "R10", ctx, eoi_stb, ee);
    if (ee) check("R9", ctx, eoi_id, wd[9:0]);
    if (req && !wr) begin
      case (a)
        8'h00: begin exp_rd = m_en; rtag = "R2"; end
        8'h04: begin exp_rd = m_mask * 16; rtag = "R3"; end
        8'h0C: begin
          exp_rd = q ? (((cand_id < 16) ? int'(cand_src) : 0) << 10) | int'(cand_id) : 1023;
          rtag = q ? "R5" : "R6";
        end
        8'h14: begin exp_rd = m_rp(); rtag = "R7"; end
        8'h18: begin exp_rd = cand_valid ? int'(cand_id) : 1023; rtag = "R11"; end
        default: begin exp_rd = 0; rtag = "R11"; end
      endcase
      check(rtag, ctx, bus_rdata, exp_rd);
    end
    if (req && wr) begin
      if (a == 8'h00) m_en = wd[0];
      if (a == 8'h04) m_mask = int'(wd[7:4]);
      if (ee) begin void'(act_id.pop_back()); void'(act_p.pop_back()); end
    end
    if (ea) begin act_id.push_back(int'(cand_id)); act_p.push_back(int'(cand_prio) >> 4); end
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic cand(bit v, int id, int p, int s);
    cand_valid = v; cand_id = 10'(id); cand_prio = 8'(p); cand_src = 3'(s);
  endtask

  task automatic rd(logic [7:0] a, string ctx);  cyc(1, 0, a, 0, ctx); endtask
  task automatic wr(logic [7:0] a, logic [31:0] d, string ctx); cyc(1, 1, a, d, ctx); endtask

  bit done = 0;
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d expected below 100000", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cand(1, 40, 8'h30, 0);
    rd(8'h00, "R1 ctrl");
    rd(8'h04, "R1 mask");
    rd(8'h14, "R1 running");
    rd(8'h0C, "R1 ack");
    wr(8'h04, 32'hFFFF_FFF7, "R3 mask write");
    rd(8'h04, "R3 low bits zero");
    cyc(0, 0, 0, 0, "R2 disabled irq low");
    rd(8'h0C, "R2 disabled ack");
    wr(8'h00, 32'hFFFF_FFFF, "R2 enable");
    rd(8'h00, "R2 bit0 only");
    wr(8'h04, 32'h30, "R4 mask 3");
    cyc(0, 0, 0, 0, "R4 equal nibble");
    cand(1, 40, 8'h2F, 0);
    cyc(0, 0, 0, 0, "R4 lower nibble");
    wr(8'h04, 32'h40, "R4 mask 4");
    cand(1, 40, 8'h3F, 0);
    cyc(0, 0, 0, 0, "R4 low bits ignored");
    wr(8'h04, 32'hF0, "mask open");
    cand(1, 5, 8'h30, 6);
    rd(8'h0C, "R5 sgi ack with source");
    rd(8'h14, "R7 running after ack");
    cand(1, 70, 8'h30, 7);
    cyc(0, 0, 0, 0, "R7 equal to running blocked");
    cand(1, 70, 8'h10, 7);
    rd(8'h0C, "R8 nested ack no source");
    cand(1, 3, 8'h00, 2);
    cyc(0, 0, 0, 0, "R8 full irq low");
    rd(8'h0C, "R8 full ack spurious");
    wr(8'h10, 5, "R10 wrong order eoi");
    rd(8'h14, "R10 running unchanged");
    wr(8'h10, 70, "R9 inner eoi");
    rd(8'h14, "R9 restored outer");
    wr(8'h10, 5, "R9 outer eoi");
    rd(8'h14, "R9 idle");
    wr(8'h10, 5, "R10 nothing active");
    cand(0, 9, 8'h00, 0);
    rd(8'h18, "R11 none pending");
    rd(8'h0C, "R6 no candidate");
    cand(1, 9, 8'h00, 0);
    rd(8'h18, "R11 pending id");
    rd(8'h20, "R11 unmapped");
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      cand($urandom_range(0, 5) != 0, $urandom_range(0, 63), $urandom_range(0, 255), $urandom_range(0, 7));
      case (op)
        0: wr(8'h00, ($urandom_range(0, 7) != 0) ? 1 : 0, "rand ctrl");
        1: wr(8'h04, $urandom, "rand mask");
        2, 3: rd(8'h0C, "rand ack");
        4, 5: wr(8'h10, (act_id.size() > 0 && $urandom_range(0, 3) != 0) ?
                   act_id[act_id.size()-1] : $urandom_range(0, 63), "rand eoi");
        6: rd(8'h14, "rand running");
        7: rd(8'h18, "rand pending");
        8: rd(8'h04, "rand mask read");
        default: cyc(0, 0, 0, 0, "rand idle");
      endcase
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule